// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block turns a device-side DMA address into a physical memory address. It uses a flat, single-level translation table that sits in system memory. Each request carries a logical address. The upper bits of that address select a table slot, and the low 12 bits are the offset within a 4096-byte page. After a bounds check, the block reads one 32-bit word from the table through a memory read port with a request/acknowledge handshake. It then returns either the translated address with read and write permission, or a fault.

Each table slot is 8 bytes wide. The first word of a slot holds the physical frame, and the second word is an owner tag that this block never fetches. Software programs the table base and the table size in bytes through a small register write port. Bit 31 of the base is ignored when the slot address is formed. The block handles one request at a time: a busy output holds off further requests until the result strobe has been given.

Top module: `dma_xlate_top`

## Requirements
- R1: After reset the base and limit registers are zero, `req_busy`, `rsp_valid` and `mem_rd_req` are low, and any request then faults without a memory read.
- R2: A request whose page index (`req_addr` >> 12) is not below `limit` >> 3 faults without any memory read, and `rsp_valid` rises in the cycle after the request is accepted.
- R3: An in-bounds request raises `mem_rd_req` in the cycle after acceptance. The address is (base with bit 31 forced to 0) + page index × 8. Both `mem_rd_req` and `mem_rd_addr` hold steady until the cycle in which `mem_rd_ack` is high.
- R4: On an acknowledged read with `mem_rd_err` low, the result is `{mem_rd_data[31:12], req_addr[11:0]}` with `rsp_fault` low and both permission outputs high. `rsp_valid` is high in the cycle after the acknowledge.
- R5: A read acknowledged with `mem_rd_err` high gives a fault. Any fault result has `rsp_addr` = 0 and both permission outputs low.
- R6: `req_busy` is high from the cycle after acceptance through the `rsp_valid` cycle. A `req_valid` raised while busy is ignored: it starts no read and produces no result.
- R7: `rsp_valid` is a single-cycle pulse, given exactly once for each accepted request.
- R8: A cycle with `cfg_we` high writes `cfg_wdata` to the base register when `cfg_sel` = 0, or to the limit register when `cfg_sel` = 1. Requests accepted in later cycles use the new value. The limit is rounded down to a whole number of 8-byte slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = table base, 1 = table limit |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Logical DMA address |
| req_busy | output | 1 | A request is in flight |
| mem_rd_req | output | 1 | Table word read request |
| mem_rd_addr | output | 32 | Byte address of the frame word |
| mem_rd_ack | input | 1 | Read acknowledge, data valid |
| mem_rd_data | input | 32 | Frame word read back |
| mem_rd_err | input | 1 | Read failed |
| rsp_valid | output | 1 | Result strobe |
| rsp_addr | output | 32 | Translated physical address, 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_perm_rd | output | 1 | Read permitted |
| rsp_perm_wr | output | 1 | Write permitted |

## Verification
The bench places the base with bit 31 set, so a design that keeps that bit reads the table at the wrong address. It requests the last in-bounds slot and the first out-of-bounds slot. It then sets the limit one byte short of, and exactly at, a whole slot, so an off-by-one comparison or a limit that is not rounded down shows up as a missing read or a stray one. It feeds a frame word with all low bits set to catch offset bits leaking from the frame. It also returns a read error to make sure the data on the port does not reach the result. Finally it raises a request while a read is stalled: a design that drops the hold-off would issue a second read or give a second strobe.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;
  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_FETCH = 2'd1,
    XS_DONE  = 2'd2
  } xlate_state_e;

  localparam logic CFG_SEL_BASE  = 1'b0;
  localparam logic CFG_SEL_LIMIT = 1'b1;
endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs
  import dma_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] tbl_base,
  output logic [ADDR_W-1:0] tbl_limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base  <= '0;
      tbl_limit <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == CFG_SEL_BASE) tbl_base  <= cfg_wdata;
      else                         tbl_limit <= cfg_wdata;
    end
  end
endmodule

// File: rtl/xlate_index.sv
module xlate_index #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_limit,
  output logic              in_bounds,
  output logic [ADDR_W-1:0] ent_addr
);
  localparam int IDX_W = ADDR_W - PAGE_SHIFT;

  function automatic logic [ADDR_W-1:0] f_slot_count(input logic [ADDR_W-1:0] lim);
    return lim >> ENTRY_SHIFT;
  endfunction

  function automatic logic [ADDR_W-1:0] f_entry_addr(input logic [ADDR_W-1:0] base,
                                                     input logic [IDX_W-1:0]  idx);
    logic [ADDR_W-1:0] off;
    off = '0;
    off[IDX_W+ENTRY_SHIFT-1:ENTRY_SHIFT] = idx;
    return {1'b0, base[ADDR_W-2:0]} + off;
  endfunction

  logic [IDX_W-1:0]  page_idx;
  logic [ADDR_W-1:0] idx_wide;

  assign page_idx  = req_addr[ADDR_W-1:PAGE_SHIFT];
  assign idx_wide  = {{PAGE_SHIFT{1'b0}}, page_idx};
  assign in_bounds = idx_wide < f_slot_count(tbl_limit);
  assign ent_addr  = f_entry_addr(tbl_base, page_idx);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import dma_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              in_bounds,
  input  logic [ADDR_W-1:0] ent_addr,
  output logic              req_busy,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              mem_rd_err,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault,
  output logic              rsp_perm_rd,
  output logic              rsp_perm_wr,
  output logic              evt_accept,
  output logic              evt_oob,
  output logic              evt_fill
);
  localparam int FRAME_W = ADDR_W - PAGE_SHIFT;

  xlate_state_e            state_q;
  logic [ADDR_W-1:0]       ent_addr_q;
  logic [PAGE_SHIFT-1:0]   offset_q;
  logic [FRAME_W-1:0]      frame_q;
  logic                    fault_q;

  assign evt_accept = (state_q == XS_IDLE) && req_valid;
  assign evt_oob    = evt_accept && !in_bounds;
  assign evt_fill   = (state_q == XS_FETCH) && mem_rd_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= XS_IDLE;
      ent_addr_q <= '0;
      offset_q   <= '0;
      frame_q    <= '0;
      fault_q    <= 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          if (evt_accept) begin
            ent_addr_q <= ent_addr;
            offset_q   <= req_addr[PAGE_SHIFT-1:0];
            if (in_bounds) begin
              state_q <= XS_FETCH;
            end else begin
              fault_q <= 1'b1;
              frame_q <= '0;
              state_q <= XS_DONE;
            end
          end
        end
        XS_FETCH: begin
          if (mem_rd_ack) begin
            fault_q <= mem_rd_err;
            frame_q <= mem_rd_err ? '0 : mem_rd_data[ADDR_W-1:PAGE_SHIFT];
            state_q <= XS_DONE;
          end
        end
        XS_DONE:  state_q <= XS_IDLE;
        default:  state_q <= XS_IDLE;
      endcase
    end
  end

  assign req_busy    = state_q != XS_IDLE;
  assign mem_rd_req  = state_q == XS_FETCH;
  assign mem_rd_addr = ent_addr_q;
  assign rsp_valid   = state_q == XS_DONE;
  assign rsp_fault   = fault_q;
  assign rsp_addr    = fault_q ? '0 : {frame_q, offset_q};
  assign rsp_perm_rd = rsp_valid && !fault_q;
  assign rsp_perm_wr = rsp_valid && !fault_q;
endmodule

// File: rtl/dma_xlate_top.sv
module dma_xlate_top #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_busy,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              mem_rd_err,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault,
  output logic              rsp_perm_rd,
  output logic              rsp_perm_wr
);
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] tbl_limit;
  logic              in_bounds;
  logic [ADDR_W-1:0] ent_addr;
  logic              evt_accept;
  logic              evt_oob;
  logic              evt_fill;

  xlate_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tbl_base  (tbl_base),
    .tbl_limit (tbl_limit)
  );

  xlate_index #(
    .ADDR_W      (ADDR_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .ENTRY_SHIFT (ENTRY_SHIFT)
  ) u_index (
    .req_addr  (req_addr),
    .tbl_base  (tbl_base),
    .tbl_limit (tbl_limit),
    .in_bounds (in_bounds),
    .ent_addr  (ent_addr)
  );

  xlate_walker #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .in_bounds   (in_bounds),
    .ent_addr    (ent_addr),
    .req_busy    (req_busy),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_data (mem_rd_data),
    .mem_rd_err  (mem_rd_err),
    .rsp_valid   (rsp_valid),
    .rsp_addr    (rsp_addr),
    .rsp_fault   (rsp_fault),
    .rsp_perm_rd (rsp_perm_rd),
    .rsp_perm_wr (rsp_perm_wr),
    .evt_accept  (evt_accept),
    .evt_oob     (evt_oob),
    .evt_fill    (evt_fill)
  );
endmodule

// File: rtl/dma_xlate_chk.sv
module dma_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_busy,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ack,
  input logic              mem_rd_err,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_fault,
  input logic              rsp_perm_rd,
  input logic              rsp_perm_wr,
  input logic              evt_accept,
  input logic              evt_oob,
  input logic              evt_fill
);
  // R2
  oob_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_oob |=> rsp_valid && rsp_fault && !mem_rd_req);

  // R3
  fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !evt_oob) |=> mem_rd_req && !rsp_valid);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> mem_rd_req && $stable(mem_rd_addr));

  // R4
  fill_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fill |=> rsp_valid && (rsp_fault == $past(mem_rd_err)));

  // R4
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_perm_rd && rsp_perm_wr);

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0) && !rsp_perm_rd && !rsp_perm_wr);

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> req_busy);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind dma_xlate_top dma_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_busy    (req_busy),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_ack  (mem_rd_ack),
  .mem_rd_err  (mem_rd_err),
  .rsp_valid   (rsp_valid),
  .rsp_addr    (rsp_addr),
  .rsp_fault   (rsp_fault),
  .rsp_perm_rd (rsp_perm_rd),
  .rsp_perm_wr (rsp_perm_wr),
  .evt_accept  (evt_accept),
  .evt_oob     (evt_oob),
  .evt_fill    (evt_fill)
);

// File: tb/dma_xlate_top_tb.sv
module dma_xlate_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;
  localparam int NVEC = 6;
  // vector: {addr[31:0], frame[31:0], err, delay[3:0]}
  localparam logic [68:0] VEC [NVEC] = '{
    {32'h0000_0123, 32'h1234_5FFF, 1'b0, 4'd0},
    {32'h0000_7ABC, 32'hABCD_E001, 1'b0, 4'd2},
    {32'h0000_8000, 32'h5555_5555, 1'b0, 4'd0},
    {32'h0000_3FFF, 32'h7777_7777, 1'b1, 4'd1},
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'd0},
    {32'h0000_5000, 32'hFFFF_FFFF, 1'b0, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_busy;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_rd_err = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic        rsp_perm_rd;
  logic        rsp_perm_wr;

  int errors = 0;
  int checks = 0;
  logic [31:0] cur_base = '0;
  logic [31:0] cur_lim = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xlate_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_busy(req_busy),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .rsp_perm_rd(rsp_perm_rd), .rsp_perm_wr(rsp_perm_wr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) cur_lim = val; else cur_base = val;
  endtask

  task automatic do_xlate(input logic [31:0] a, input logic [31:0] frame, input logic err,
                          input int delay, input logic poke, input string tag);
    logic [31:0] idx;
    logic        inb;
    logic        exp_fault;
    logic [31:0] exp_mem;
    logic [31:0] exp_out;
    int          w;
    int          lat;
    logic        seen_rd;
    logic        got;
    idx       = a >> 12;
    inb       = idx < (cur_lim / 8);
    exp_fault = !inb || err;
    exp_mem   = (cur_base % 32'h8000_0000) + (idx * 8);
    exp_out   = exp_fault ? 32'h0 : ((frame / 4096) * 4096) + (a % 4096);
    w = 0; lat = -1; seen_rd = 1'b0; got = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 60 && !got; c++) begin
      if (poke && c == 0) begin
        chk({tag, " R6 busy while in flight"}, {31'b0, req_busy}, 32'd1);
        req_valid = 1'b1; req_addr = 32'hFFFF_F000;
      end
      if (rsp_valid) begin
        got = 1'b1; lat = c;
        req_valid = 1'b0;
        chk({tag, " R4/R5 fault"}, {31'b0, rsp_fault}, {31'b0, exp_fault});
        chk({tag, " R4/R5 address"}, rsp_addr, exp_out);
        chk({tag, " R4/R5 perms"}, {30'b0, rsp_perm_rd, rsp_perm_wr},
            exp_fault ? 32'd0 : 32'd3);
        chk({tag, " R6 busy at strobe"}, {31'b0, req_busy}, 32'd1);
      end else if (mem_rd_req) begin
        if (!seen_rd) chk({tag, " R3 entry address"}, mem_rd_addr, exp_mem);
        seen_rd = 1'b1;
        if (w == delay) begin
          mem_rd_ack = 1'b1; mem_rd_data = frame; mem_rd_err = err;
          req_valid = 1'b0;
        end
        w++;
      end
      @(negedge clk);
      mem_rd_ack = 1'b0; mem_rd_data = '0; mem_rd_err = 1'b0;
    end
    chk({tag, " R2/R3 read issued"}, {31'b0, seen_rd}, {31'b0, inb});
    chk({tag, " R2/R4 latency"}, lat, inb ? delay + 1 : 0);
    chk({tag, " R7 pulse ends"}, {31'b0, rsp_valid}, 32'd0);
    chk({tag, " R6 busy cleared"}, {31'b0, req_busy}, 32'd0);
    if (poke) begin
      logic extra;
      extra = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (rsp_valid || mem_rd_req) extra = 1'b1;
        @(negedge clk);
      end
      chk({tag, " R6 request while busy ignored"}, {31'b0, extra}, 32'd0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy after reset", {31'b0, req_busy}, 32'd0);
    chk("R1 strobe after reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 no read after reset", {31'b0, mem_rd_req}, 32'd0);
    // R1 unprogrammed table faults without a read
    do_xlate(32'h0000_0000, 32'h1111_1000, 1'b0, 0, 1'b0, "R1 zero table");

    // R8 program base (bit 31 set) and limit of 8 slots
    cfg_write(1'b0, 32'h8000_1000);
    cfg_write(1'b1, 32'h0000_0040);
    for (int i = 0; i < NVEC; i++) begin
      do_xlate(VEC[i][68:37], VEC[i][36:5], VEC[i][4], int'(VEC[i][3:0]), 1'b0,
               $sformatf("vec%0d", i));
    end

    // R6 request raised while a read is stalled
    do_xlate(32'h0000_2010, 32'h0042_0000, 1'b0, 4, 1'b1, "R6 stalled read");

    // R8 limit rounding: 0x47 still 8 slots, 0x48 gives 9
    cfg_write(1'b1, 32'h0000_0047);
    do_xlate(32'h0000_8004, 32'h0990_0000, 1'b0, 0, 1'b0, "R8 limit short");
    cfg_write(1'b1, 32'h0000_0048);
    do_xlate(32'h0000_8004, 32'h0990_0000, 1'b0, 1, 1'b0, "R8 limit exact");

    // R8 new base takes effect
    cfg_write(1'b0, 32'h0010_0000);
    do_xlate(32'h0000_1FFC, 32'h3000_0ABC, 1'b0, 0, 1'b0, "R8 new base");

    finish_run();
  end
endmodule